// File: doc/BRIEF.md
# Power-Down and Start-Up Sequencer

This block controls how the digital output path of a stereo converter leaves and enters power-down. It watches an active-low power-down request and the frame clock, and it drives three control outputs: a reset for the decimation filter and serial logic, a zero-force flag that makes the sample path send two's-complement zero, and a ready flag. The serial data stream also passes through the block, which holds it low while the path is powered down.

When the power-down request is released, the block counts frame-clock rising edges. It keeps the samples forced to zero until the initialization interval has run out. The length of that interval depends on the clocking role that was selected while the block was powered down: 4129 frames when the converter drives the frame clock and 4132 when it receives it. The power-down input, the frame clock and the serial data are sampled on the system clock. Any low level on the request restarts the whole sequence.

Top module: `pds_seq_top`

## Requirements
- R1: No more than three system-clock edges after `pd_n_i` goes low, `dp_rst_o`=1, `zero_force_o`=1 and `ready_o`=0. These values hold while `pd_n_i` stays low, and frame-clock edges in that time have no effect.
- R2: With the role latched as master (`master_i`=1), `ready_o` rises after exactly MASTER_WAIT frame-clock rising edges (default 4129) seen in the initialization state. It rises on the third system-clock edge after the last of those edges is applied.
- R3: With the role latched as slave (`master_i`=0), `ready_o` rises after exactly SLAVE_WAIT frame-clock rising edges (default 4132), with the same latency as in R2.
- R4: During initialization, `dp_rst_o`=0, `zero_force_o`=1 and `ready_o`=0.
- R5: `ser_o` is 0 whenever `dp_rst_o` is 1, whatever the value of `ser_i`.
- R6: Outside power-down, `ser_o` equals `ser_i` delayed by one system clock.
- R7: The frame counter is CNT_W bits wide (default 13) and saturates at its terminal count. Once `ready_o` is high, it stays high for any number of further frame edges while `pd_n_i` stays high.
- R8: A power-down request during initialization discards the partial count. The next release needs the full interval again.
- R9: The role is sampled only while in power-down. A change to `master_i` after release does not alter the interval until the next power-down.
- R10: While `rst` is high, and on the first edge after it, the outputs show the power-down state: `dp_rst_o`=1, `zero_force_o`=1, `ready_o`=0 and `ser_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pd_n_i | input | 1 | Asynchronous power-down request, active low |
| frame_clk_i | input | 1 | Frame (sample-rate) clock, sampled on `clk` |
| master_i | input | 1 | Clocking role: 1 = master, 0 = slave |
| ser_i | input | 1 | Serial data from the output shifter |
| dp_rst_o | output | 1 | Reset for the filter and serial logic |
| zero_force_o | output | 1 | Force output samples to two's-complement zero |
| ready_o | output | 1 | Output data valid |
| ser_o | output | 1 | Gated serial data output |

## Verification
A counter that is off by one, or that is preloaded from the wrong role, moves the rising edge of `ready_o` by a whole frame period. The bench catches this at the exact frame edge where the flag should or should not change. If a stale count survives a power-down, `ready_o` rises too early in the restart sweep, within the first few frames. A state machine that leaves power-down or run at the wrong time shows at once as a wrong combination of `dp_rst_o`, `zero_force_o` and `ser_o`, within three system clocks of the stimulus.

// File: rtl/pds_pkg.sv
package pds_pkg;
  typedef enum logic [1:0] {
    ST_PD   = 2'd0,
    ST_INIT = 2'd1,
    ST_RUN  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/pds_sync.sv
// Multi-stage synchronizer, one chain per bit.
module pds_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/pds_edge.sv
// Rising-edge detector on an already synchronized level.
module pds_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_d;
  always_ff @(posedge clk) begin
    if (rst) lvl_d <= 1'b0;
    else     lvl_d <= lvl_i;
  end
  assign rise_o = lvl_i & ~lvl_d;
endmodule

// File: rtl/pds_init_cnt.sv
// Saturating frame counter; last_o flags the increment that reaches term_i.
module pds_init_cnt #(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [CNT_W-1:0] term_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;
  always_ff @(posedge clk) begin
    if (rst || clr_i)                 cnt_q <= '0;
    else if (inc_i && cnt_q != term_i) cnt_q <= cnt_q + CNT_W'(1);
  end
  assign cnt_o  = cnt_q;
  assign last_o = inc_i && (cnt_q == term_i - CNT_W'(1));
endmodule

// File: rtl/pds_seq_top.sv
module pds_seq_top #(
  parameter int CNT_W       = 13,
  parameter int MASTER_WAIT = 4129,
  parameter int SLAVE_WAIT  = 4132,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pd_n_i,
  input  logic frame_clk_i,
  input  logic master_i,
  input  logic ser_i,
  output logic dp_rst_o,
  output logic zero_force_o,
  output logic ready_o,
  output logic ser_o
);
  import pds_pkg::*;

  localparam logic [CNT_W-1:0] TERM_M = CNT_W'(MASTER_WAIT);
  localparam logic [CNT_W-1:0] TERM_S = CNT_W'(SLAVE_WAIT);

  logic [1:0] sync_in, sync_out;
  logic pd_sync, fc_sync, fc_rise;
  logic role_q;
  logic [CNT_W-1:0] term, cnt;
  logic cnt_last;
  seq_state_e st, nxt;

  assign sync_in = {pd_n_i, frame_clk_i};

  pds_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk(clk), .rst(rst), .d_i(sync_in), .q_o(sync_out)
  );
  assign pd_sync = sync_out[1];
  assign fc_sync = sync_out[0];

  pds_edge u_edge (.clk(clk), .rst(rst), .lvl_i(fc_sync), .rise_o(fc_rise));

  assign term = role_q ? TERM_M : TERM_S;

  pds_init_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst),
    .clr_i(st == ST_PD),
    .inc_i((st == ST_INIT) && fc_rise),
    .term_i(term),
    .cnt_o(cnt),
    .last_o(cnt_last)
  );

  always_comb begin
    nxt = st;
    case (st)
      ST_PD:   if (pd_sync)  nxt = ST_INIT;
      ST_INIT: if (cnt_last) nxt = ST_RUN;
      ST_RUN:  nxt = ST_RUN;
      default: nxt = ST_PD;
    endcase
    if (!pd_sync) nxt = ST_PD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_PD;
      role_q       <= 1'b1;
      dp_rst_o     <= 1'b1;
      zero_force_o <= 1'b1;
      ready_o      <= 1'b0;
      ser_o        <= 1'b0;
    end else begin
      st           <= nxt;
      if (st == ST_PD) role_q <= master_i;
      dp_rst_o     <= (nxt == ST_PD);
      zero_force_o <= (nxt != ST_RUN);
      ready_o      <= (nxt == ST_RUN);
      ser_o        <= (nxt == ST_PD) ? 1'b0 : ser_i;
    end
  end
endmodule

// File: rtl/pds_seq_chk.sv
module pds_seq_chk #(
  parameter int CNT_W = 13
) (
  input logic             clk,
  input logic             rst,
  input logic             pd_sync,
  input logic             fc_rise,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] term,
  input logic             dp_rst_o,
  input logic             zero_force_o,
  input logic             ready_o,
  input logic             ser_o
);
  a_r1_pd_forces_reset: assert property (@(posedge clk) disable iff (rst)
    !pd_sync |=> (dp_rst_o && zero_force_o && !ready_o));

  a_r2_ready_on_frame_edge: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_o) |-> $past(fc_rise));

  a_r4_init_zeroed: assert property (@(posedge clk) disable iff (rst)
    (!dp_rst_o && !ready_o) |-> zero_force_o);

  a_r5_ser_low_in_pd: assert property (@(posedge clk) disable iff (rst)
    dp_rst_o |-> !ser_o);

  a_r7_cnt_bounded: assert property (@(posedge clk) disable iff (rst)
    cnt <= term);

  a_r7_run_holds: assert property (@(posedge clk) disable iff (rst)
    (ready_o && pd_sync) |=> ready_o);
endmodule

bind pds_seq_top pds_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .pd_sync(pd_sync), .fc_rise(fc_rise),
  .cnt(cnt), .term(term), .dp_rst_o(dp_rst_o),
  .zero_force_o(zero_force_o), .ready_o(ready_o), .ser_o(ser_o)
);

// File: tb/sim_pds_seq_top.sv
module sim_pds_seq_top;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 4;
  localparam int MW = 5;
  localparam int SW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pd_n = 1'b0, fc = 1'b0, master = 1'b1, ser = 1'b0;
  logic dp_rst, zf, rdy, sero;
  int tests = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pds_seq_top #(.CNT_W(CW), .MASTER_WAIT(MW), .SLAVE_WAIT(SW)) u0 (
    .clk(clk), .rst(rst), .pd_n_i(pd_n), .frame_clk_i(fc), .master_i(master),
    .ser_i(ser), .dp_rst_o(dp_rst), .zero_force_o(zf), .ready_o(rdy), .ser_o(sero)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // outputs packed as {dp_rst, zf, rdy}
  task automatic chk_state(input logic [2:0] exp, input string tag);
    chk({dp_rst, zf, rdy} == exp, tag, int'({dp_rst, zf, rdy}), int'(exp));
  endtask

  task automatic frame_pulse();
    fc = 1'b1; step(3); fc = 1'b0; step(3);
  endtask

  task automatic power_down();
    pd_n = 1'b0; step(4);
  endtask

  task automatic release_pd();
    pd_n = 1'b1; step(4);
    chk_state(3'b010, "R4 init outputs");
  endtask

  // n frames: n-1 leave ready low, the n-th raises it on the third clock edge
  task automatic count_to(input int n, input string tag);
    for (int k = 1; k < n; k++) begin
      frame_pulse();
      chk(rdy == 1'b0, tag, rdy, 0);
      chk(zf == 1'b1, "R4 zero forced in init", zf, 1);
    end
    fc = 1'b1; step(2);
    chk(rdy == 1'b0, tag, rdy, 0);
    step(1);
    chk(rdy == 1'b1, tag, rdy, 1);
    chk_state(3'b001, "R4 run outputs");
    step(2); fc = 1'b0; step(3);
  endtask

  initial begin
    ser = 1'b1;
    step(3);
    chk_state(3'b110, "R10 reset outputs");
    chk(sero == 1'b0, "R10 ser low in reset", sero, 0);
    rst = 1'b0;
    step(2);
    // held in power-down: frame edges ignored, serial forced low
    for (int k = 0; k < 12; k++) frame_pulse();
    chk_state(3'b110, "R1 frames ignored in power-down");
    chk(sero == 1'b0, "R5 ser low in power-down", sero, 0);

    // master interval
    master = 1'b1;
    release_pd();
    count_to(MW, "R2 master interval");

    // serial pass-through, one clock delay
    for (int k = 0; k < 6; k++) begin
      ser = k[0];
      step(1);
      chk(sero == k[0], "R6 serial pass-through", sero, int'(k[0]));
    end

    // saturation: many more frames keep ready
    for (int k = 0; k < 3 * (1 << CW); k++) frame_pulse();
    chk(rdy == 1'b1, "R7 ready held after saturation", rdy, 1);

    // power-down latency from run
    ser = 1'b1;
    pd_n = 1'b0; step(2);
    chk(rdy == 1'b1, "R1 latency before edge three", rdy, 1);
    step(1);
    chk_state(3'b110, "R1 power-down from run");
    chk(sero == 1'b0, "R5 ser low after power-down", sero, 0);
    step(2);

    // slave interval
    master = 1'b0;
    release_pd();
    count_to(SW, "R3 slave interval");

    // restart in the middle of initialization
    power_down();
    release_pd();
    for (int k = 0; k < SW - 2; k++) frame_pulse();
    chk(rdy == 1'b0, "R8 partial count", rdy, 0);
    power_down();
    chk_state(3'b110, "R8 power-down in init");
    release_pd();
    count_to(SW, "R8 full interval after restart");

    // role change after release is ignored
    power_down();
    master = 1'b1;
    release_pd();
    master = 1'b0;
    count_to(MW, "R9 role latched at release");
    power_down();
    release_pd();
    count_to(SW, "R9 new role after power-down");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule